// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects an on-chip requester to an external asynchronous static RAM with a 16-bit data bus and two byte-lane strobes. The requester presents one request at a time over a ready/valid handshake. A request carries an address, a 16-bit write word, a read/write flag and a two-bit lane mask. The controller then runs the memory's control pins through a fixed sequence of phases, each a whole number of clock cycles long. Every phase length is derived at elaboration from the clock period and the memory's nanosecond minimums, so the same RTL serves any clock rate.

A read holds the address, chip select, output enable and lane strobes for the access window. It captures the bus at the last edge of that window and returns the word with a single-cycle valid pulse. A write has three parts: a setup cycle, a write-enable pulse long enough for pulse width, address-to-end and data setup, and one recovery cycle. In the recovery cycle the controller keeps driving the data bus after write enable has risen. Output enable stays high for the whole write. Every access ends with one cycle in which the chip is deselected, so the memory's output drivers have time to turn off before the next access.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is asserted and right after its release, every active-low memory control (`sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_lb_n`, `sram_ub_n`) is high, `sram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the access and one trailing deselected cycle are over. At 50 MHz with the default timings this is 5 cycles for a read and 6 cycles for a write. While `req_ready` is 1, chip select and both strobes are high and the data drivers are off.
- R3: A read drives chip select and output enable low and write enable high for `ceil(T_READ_NS/CLK_NS)` cycles (minimum 1; 4 at the defaults). Each cycle count in the design is the ceiling of the relevant nanosecond minimum over the clock period, never less than 1.
- R4: Read data is sampled at the clock edge that ends the access window. `rd_valid` is high for exactly the following cycle. Mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8. A lane whose mask bit is 0 returns zero.
- R5: A write consists of one cycle with chip select low and write enable high, then write enable low for the longest of the pulse-width, data-setup, address-to-end-minus-one and cycle-time-minus-one counts (3 at the defaults), then one cycle with write enable high and chip select still low. Output enable is high throughout.
- R6: `sram_dq_oe` is 1 only while write enable is low and during the single cycle after it rises. `sram_dq_out` then carries the request's write word.
- R7: `sram_addr` changes only on an edge where write enable is high both before and after the edge. The address stays at the requested value for as long as chip select is low.
- R8: After chip select rises at the end of an access, it stays high for at least one full cycle.
- R9: While chip select is low, each lane strobe is low exactly when its mask bit is 1. A mask of 00 asserts no strobe, so a write changes no memory byte and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read word, unselected lanes zero |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |
| sram_dq_out | output | 16 | Data to the bus pad |
| sram_dq_oe | output | 1 | Bus pad output enable |
| sram_dq_in | input | 16 | Data from the bus pad |

## Verification
A wrong phase state or timer value shows up within the same access. The write-enable pulse or output-enable window has the wrong number of cycles, or `req_ready` returns early or late. The bench counts these per access. A capture on the wrong edge samples the bench memory's filler pattern instead of the stored word, and the lane mask on every read exposes a swapped or unmasked lane. A write that lands in the wrong lane or at the wrong address stays hidden until the read-back sweep, at most one full sweep later.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  localparam int DQ_W   = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DQ_W / LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } ctl_state_e;

  // ceiling of ns / period, never below one cycle
  function automatic int cyc_from_ns(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
  import sram_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [LANES-1:0] lane_en,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  rd_data,
  output logic             rd_valid
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (capture)
        lane_q <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
    assign rd_data[g*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= capture;
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int CLK_NS       = 20,
  parameter int T_READ_NS    = 70,
  parameter int T_WPULSE_NS  = 55,
  parameter int T_ADDR_END_NS = 60,
  parameter int T_DSETUP_NS  = 30,
  parameter int T_WCYCLE_NS  = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [15:0]       sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_in
);

  localparam int RD_CYC    = cyc_from_ns(T_READ_NS,     CLK_NS);
  localparam int WP_CYC    = cyc_from_ns(T_WPULSE_NS,   CLK_NS);
  localparam int AW_CYC    = cyc_from_ns(T_ADDR_END_NS, CLK_NS);
  localparam int DW_CYC    = cyc_from_ns(T_DSETUP_NS,   CLK_NS);
  localparam int WC_CYC    = cyc_from_ns(T_WCYCLE_NS,   CLK_NS);
  // one setup cycle precedes the pulse, so it counts toward address and cycle time
  localparam int PULSE_CYC = imax(imax(WP_CYC, DW_CYC), imax(AW_CYC - 1, WC_CYC - 1));
  localparam int CNT_W     = $clog2(imax(RD_CYC, PULSE_CYC) + 1);

  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [LANES-1:0]  mask_q, mask_nx;
  logic              accept;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic              capture;
  logic              ce_n_d, we_n_d, oe_n_d, lb_n_d, ub_n_d, dq_oe_d, active_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_nx   = accept ? req_mask : mask_q;

  // next-state and phase timer control
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(RD_CYC);
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d  = ST_RD_ACC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC);
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_expired) begin
          state_d = ST_TURN;
          capture = 1'b1;
        end
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PULSE_CYC);
      end
      ST_WR_PULSE: begin
        if (tmr_expired) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: state_d = ST_TURN;
      ST_TURN:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // pin values for the coming cycle, decoded from the next state
  always_comb begin
    active_d = (state_d != ST_IDLE) && (state_d != ST_TURN);
    ce_n_d   = !active_d;
    oe_n_d   = (state_d != ST_RD_ACC);
    we_n_d   = (state_d != ST_WR_PULSE);
    lb_n_d   = !(active_d && mask_nx[0]);
    ub_n_d   = !(active_d && mask_nx[1]);
    dq_oe_d  = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, clock-enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  // registered memory pins, glitch free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_lb_n  <= 1'b1;
      sram_ub_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_ce_n  <= ce_n_d;
      sram_we_n  <= we_n_d;
      sram_oe_n  <= oe_n_d;
      sram_lb_n  <= lb_n_d;
      sram_ub_n  <= ub_n_d;
      sram_dq_oe <= dq_oe_d;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_rd_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .lane_en  (mask_q),
    .dq_in    (sram_dq_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n)));

  // R5
  write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n));

  // R3
  read_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n));

  // R6
  drv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n || !$past(sram_we_n)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_lb_n && sram_ub_n && !sram_dq_oe));

  // R8
  ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |=> sram_ce_n);

endmodule

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;

  localparam int AW = 18;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_mask;
  logic          rd_valid;
  logic [15:0]   rd_data;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
  logic [15:0]   sram_dq_out;
  logic          sram_dq_oe;
  logic [15:0]   sram_dq_in;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] mem     [64];
  logic [15:0] exp_mem [64];
  logic        prev_we_n;

  async_sram_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model: drives only during a genuine read, filler otherwise
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[5:0]] : 16'hBAD0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write commit on the rising edge of write enable, sampled away from the clock edge
  always @(negedge clk) begin
    if (rst_n && prev_we_n === 1'b0 && sram_we_n === 1'b1 && sram_ce_n === 1'b0) begin
      check("R6 drivers on at end of write", {31'd0, sram_dq_oe}, 32'd1);
      if (!sram_lb_n) mem[sram_addr[5:0]][7:0]  = sram_dq_out[7:0];
      if (!sram_ub_n) mem[sram_addr[5:0]][15:8] = sram_dq_out[15:8];
    end
    prev_we_n = sram_we_n;
  end

  function automatic logic [AW-1:0] addr_of(input int i);
    return {12'((i * 37) + 5), 6'(i)};
  endfunction

  function automatic logic [15:0] lane_sel(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rdat);
    int busy, we_lo, oe_lo, ce_lo, drv, rv, rv_at, n;
    bit addr_ok, strb_ok;
    busy = 0; we_lo = 0; oe_lo = 0; ce_lo = 0; drv = 0; rv = 0; rv_at = 0; n = 0;
    addr_ok = 1; strb_ok = 1; rdat = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && n < 50) begin
      n++;
      busy++;
      if (!sram_we_n) we_lo++;
      if (!sram_oe_n) oe_lo++;
      if (sram_dq_oe) drv++;
      if (!sram_ce_n) begin
        ce_lo++;
        if (sram_addr !== a) addr_ok = 0;
        if ({sram_ub_n, sram_lb_n} !== ~m) strb_ok = 0;
      end
      if (rd_valid) begin rv++; rv_at = n; rdat = rd_data; end
      @(negedge clk);
    end
    check("R7 address held while selected", {31'd0, addr_ok}, 32'd1);
    check("R9 strobes follow mask", {31'd0, strb_ok}, 32'd1);
    check("R8 chip deselected before ready", 32'(ce_lo), wr ? 32'd5 : 32'd4);
    if (wr) begin
      check("R2 write busy cycles", 32'(busy), 32'd6);
      check("R5 write pulse cycles", 32'(we_lo), 32'd3);
      check("R5 output enable high in write", 32'(oe_lo), 32'd0);
      check("R6 driver cycles", 32'(drv), 32'd4);
      check("R4 no valid on write", 32'(rv), 32'd0);
    end else begin
      check("R2 read busy cycles", 32'(busy), 32'd5);
      check("R3 read output enable cycles", 32'(oe_lo), 32'd4);
      check("R3 write enable high in read", 32'(we_lo), 32'd0);
      check("R6 no drive in read", 32'(drv), 32'd0);
      check("R4 single valid pulse", 32'(rv), 32'd1);
      check("R4 valid cycle after window", 32'(rv_at), 32'd5);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [15:0] wd;
    for (int k = 0; k < 64; k++) begin
      mem[k]     = 16'h5A00 ^ 16'(k * 16'h0301);
      exp_mem[k] = 16'h5A00 ^ 16'(k * 16'h0301);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0; prev_we_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 controls during reset",
          {25'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, rd_valid},
          {25'd0, 7'b1111100});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 controls after reset",
          {24'd0, req_ready, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, rd_valid},
          {24'd0, 8'b11111100});

    // read initial contents with every mask
    for (int i = 0; i < 8; i++)
      for (int m = 0; m < 4; m++) begin
        access(1'b0, addr_of(i), 16'h0, 2'(m), got);
        check("R4 initial read lanes", 32'(got), 32'(lane_sel(exp_mem[i], 2'(m))));
      end

    // write sweep over addresses and masks
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 16; i++) begin
        wd = 16'((i * 16'h1357) + (m * 16'h0F0F) + 16'h2001);
        access(1'b1, addr_of(i), wd, 2'(m), got);
        if (m[0]) exp_mem[i][7:0]  = wd[7:0];
        if (m[1]) exp_mem[i][15:8] = wd[15:8];
      end

    // read back sweep, including mask 00 returning zero (R9)
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++) begin
        access(1'b0, addr_of(i), 16'h0, 2'(m), got);
        check("R4 readback lanes", 32'(got), 32'(lane_sel(exp_mem[i], 2'(m))));
      end

    // untouched location remains intact after the sweep
    access(1'b0, addr_of(40), 16'h0, 2'b11, got);
    check("R9 untouched word", 32'(got), 32'(exp_mem[40]));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule